// File: doc/BRIEF.md
# Fractional Tuning Dither for an Oscillator Control Word

This block lets a tuning path that can only place whole capacitor steps reach a finer average setting. It takes a wide tuning word and splits it at a fixed point. The upper field is passed on as the coarse capacitor code. The lower field is the fraction, and it drives a first-order delta-sigma accumulator. The carry out of that accumulator turns one extra unit capacitor on or off. Over many updates, the share of time this single switch is on equals the fraction divided by 2^FRAC_W.

The block runs on the fast oscillator clock. An internal divider produces an update enable on every second edge. The tuning word is sampled only on those update edges. The coarse code and the dither bit are registered there and hold their values in between. Reset clears the divider, the accumulator and both outputs. The first update after reset falls on the second rising edge.

Top module: `tune_dither_top`

## Requirements
- R1: On each update edge, `coarse_code` takes bits [13:6] of `tune_word`. These are the upper WORD_W-FRAC_W bits.
- R2: On each update edge, the 6-bit fraction `tune_word[5:0]` is added to the 6-bit accumulator. `dither_bit` becomes the carry out of that sum, and the accumulator keeps the sum modulo 64.
- R3: With the default DIV_LOG2=1, an update happens on every second rising clock edge. On the edges between updates, `coarse_code`, `dither_bit` and the accumulator do not change.
- R4: Changes to `tune_word` between update edges are ignored. Only the value present at the next update edge reaches the outputs.
- R5: From reset, with a constant fraction f, exactly f of the first 64 updates give `dither_bit` = 1.
- R6: A fraction of 0 gives `dither_bit` = 0 on every update.
- R7: A fraction of 63 gives exactly one zero in every 64 updates. Whenever the accumulator is non-zero, the update gives a 1.
- R8: While `rst_n` is low, `coarse_code` and `dither_bit` are 0 and the accumulator and divider are cleared. After `rst_n` is released, the first update occurs on the second rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tune_word | input | WORD_W (14) | Tuning word: coarse field above, fraction below |
| coarse_code | output | WORD_W-FRAC_W (8) | Registered coarse capacitor code |
| dither_bit | output | 1 | Registered switch control for the dithered unit capacitor |

## Verification
The assertions check four things on every cycle. Updates alternate with idle edges. Outputs and accumulator state hold still on idle edges. The coarse field is copied on each update. A zero fraction never produces a carry, and a full fraction always carries from a non-zero accumulator. Other behaviour shows only across the bench's scenarios: the exact carry sequence for a given fraction, the long-run count of ones over 64 updates, the rejection of a word changed between updates, and the clearing of the accumulator by a mid-run reset.

// File: rtl/tdd_pkg.sv
package tdd_pkg;
   // Default split of the tuning word
   localparam int TDD_WORD_W   = 14;
   localparam int TDD_FRAC_W   = 6;
   // log2 of the oscillator-to-update rate ratio
   localparam int TDD_DIV_LOG2 = 1;
endpackage

// File: rtl/tdd_rate_div.sv
module tdd_rate_div #(
   parameter int DIV_LOG2 = tdd_pkg::TDD_DIV_LOG2
) (
   input  logic clk,
   input  logic rst_n,
   output logic upd_en
);
   logic [DIV_LOG2-1:0] phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase_q <= '0;
      else        phase_q <= phase_q + 1'b1;
   end

   // Update on the last phase of each divider period
   assign upd_en = &phase_q;
endmodule

// File: rtl/tdd_coarse_reg.sv
module tdd_coarse_reg #(
   parameter int W = tdd_pkg::TDD_WORD_W - tdd_pkg::TDD_FRAC_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         upd_en,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= '0;
      else if (upd_en) q <= d;
   end
endmodule

// File: rtl/tdd_dsm_accum.sv
module tdd_dsm_accum #(
   parameter int FRAC_W = tdd_pkg::TDD_FRAC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd_en,
   input  logic [FRAC_W-1:0] frac_in,
   output logic              carry_o,
   output logic [FRAC_W-1:0] acc_o
);
   localparam int SUM_W = FRAC_W + 1;

   logic [SUM_W-1:0] sum;

   assign sum = {1'b0, acc_o} + {1'b0, frac_in};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_o   <= '0;
         carry_o <= 1'b0;
      end else if (upd_en) begin
         acc_o   <= sum[FRAC_W-1:0];
         carry_o <= sum[SUM_W-1];
      end
   end
endmodule

// File: rtl/tune_dither_top.sv
module tune_dither_top #(
   parameter int WORD_W   = tdd_pkg::TDD_WORD_W,
   parameter int FRAC_W   = tdd_pkg::TDD_FRAC_W,
   parameter int DIV_LOG2 = tdd_pkg::TDD_DIV_LOG2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [WORD_W-1:0]        tune_word,
   output logic [WORD_W-FRAC_W-1:0] coarse_code,
   output logic                     dither_bit
);
   localparam int COARSE_W = WORD_W - FRAC_W;

   generate
      if (FRAC_W < 1) begin : g_bad_frac
         $error("FRAC_W must be at least 1");
      end
      if (COARSE_W < 1) begin : g_bad_split
         $error("WORD_W must exceed FRAC_W");
      end
      if (DIV_LOG2 < 1) begin : g_bad_div
         $error("DIV_LOG2 must be at least 1");
      end
   endgenerate

   logic              upd_en;
   logic [FRAC_W-1:0] acc_state;

   tdd_rate_div #(.DIV_LOG2(DIV_LOG2)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .upd_en (upd_en)
   );

   tdd_coarse_reg #(.W(COARSE_W)) u_coarse (
      .clk    (clk),
      .rst_n  (rst_n),
      .upd_en (upd_en),
      .d      (tune_word[WORD_W-1:FRAC_W]),
      .q      (coarse_code)
   );

   tdd_dsm_accum #(.FRAC_W(FRAC_W)) u_dsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .upd_en  (upd_en),
      .frac_in (tune_word[FRAC_W-1:0]),
      .carry_o (dither_bit),
      .acc_o   (acc_state)
   );
endmodule

// File: rtl/tdd_checker.sv
module tdd_checker #(
   parameter int WORD_W   = 14,
   parameter int FRAC_W   = 6,
   parameter int DIV_LOG2 = 1
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     upd_en,
   input logic [WORD_W-1:0]        tune_word,
   input logic [WORD_W-FRAC_W-1:0] coarse_code,
   input logic                     dither_bit,
   input logic [FRAC_W-1:0]        acc
);
   AST_UPD_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en |=> !upd_en); // R3

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_en |=> ($stable(coarse_code) && $stable(dither_bit) && $stable(acc))); // R3

   AST_COARSE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en |=> (coarse_code == $past(tune_word[WORD_W-1:FRAC_W]))); // R1

   AST_ZERO_FRAC_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && (tune_word[FRAC_W-1:0] == '0)) |=> !dither_bit); // R6

   AST_FULL_FRAC_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && (&tune_word[FRAC_W-1:0]) && (acc != '0)) |=> dither_bit); // R7
endmodule

bind tune_dither_top tdd_checker #(
   .WORD_W(WORD_W), .FRAC_W(FRAC_W), .DIV_LOG2(DIV_LOG2)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .upd_en      (upd_en),
   .tune_word   (tune_word),
   .coarse_code (coarse_code),
   .dither_bit  (dither_bit),
   .acc         (acc_state)
);

// File: tb/tune_dither_top_bench.sv
`timescale 1ns/1ps
module tune_dither_top_bench;
   localparam int NV = 6;
   localparam logic [13:0] VEC_WORD [NV] = '{
      {8'd0,   6'd0},  {8'd255, 6'd63}, {8'd165, 6'd32},
      {8'd1,   6'd1},  {8'd200, 6'd21}, {8'd128, 6'd48}};
   localparam int VEC_COARSE [NV] = '{0, 255, 165, 1, 200, 128};
   localparam int VEC_ONES   [NV] = '{0, 63, 32, 1, 21, 48};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [13:0] tune_word = '0;
   logic [7:0]  coarse_code;
   logic        dither_bit;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   tune_dither_top u_tune_dither_top (
      .clk(clk), .rst_n(rst_n), .tune_word(tune_word),
      .coarse_code(coarse_code), .dither_bit(dither_bit));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // advance to the next update edge and sample after it
   task automatic next_update();
      repeat (2) @(posedge clk);
      #1;
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // R8: reset state
      tune_word = {8'd77, 6'd5};
      repeat (2) @(negedge clk);
      chk("R8 coarse in reset", coarse_code, 0);
      chk("R8 dither in reset", dither_bit, 0);

      // R5, R1, R6, R7: vector table
      for (int v = 0; v < NV; v++) begin
         int ones;
         ones = 0;
         do_reset();
         tune_word = VEC_WORD[v];
         for (int u = 0; u < 64; u++) begin
            next_update();
            ones += dither_bit;
         end
         chk("R1 coarse field", coarse_code, VEC_COARSE[v]);
         chk("R5 ones in 64 updates", ones, VEC_ONES[v]);
         if (VEC_ONES[v] == 0)  chk("R6 zero fraction ones", ones, 0);
         if (VEC_ONES[v] == 63) chk("R7 full fraction ones", ones, 63);
      end

      // R8, R3: first update on second edge, idle edge holds
      do_reset();
      tune_word = {8'd90, 6'd40};
      @(posedge clk); #1;
      chk("R8 no update on first edge", coarse_code, 0);
      chk("R3 idle edge holds dither", dither_bit, 0);
      @(posedge clk); #1;
      chk("R8 update on second edge", coarse_code, 90);

      // R2: exact carry sequence for fraction 40 (first update already done)
      begin
         int acc_m;
         int exp_d;
         acc_m = 40;
         chk("R2 carry update 1", dither_bit, 0);
         for (int u = 2; u <= 8; u++) begin
            next_update();
            exp_d = (acc_m + 40) / 64;
            acc_m = (acc_m + 40) % 64;
            chk("R2 carry sequence", dither_bit, exp_d);
         end
      end

      // R4: word changed between updates is ignored until the next update
      tune_word = {8'd17, 6'd0};
      @(posedge clk); #1;
      chk("R4 coarse held on idle edge", coarse_code, 90);
      tune_word = {8'd33, 6'd0};
      @(posedge clk); #1;
      chk("R4 only update-edge word taken", coarse_code, 33);
      chk("R3 zero fraction after update", dither_bit, 0);

      // R8: mid-run reset clears the accumulator
      tune_word = {8'd4, 6'd40};
      next_update();
      next_update();
      do_reset();
      chk("R8 coarse cleared", coarse_code, 0);
      next_update();
      chk("R8 accumulator restarts from zero", dither_bit, 0);
      next_update();
      chk("R8 second update carries", dither_bit, 1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule